// File: doc/BRIEF.md
# SIMD Pairwise Lane Adder

This block forms the pairwise sums of neighbouring vector elements. The two 128-bit source operands are first joined into one working vector, with operand B in the upper half and operand A in the lower half. Every two adjacent elements of that joined vector are then added to give one result element. The element width is chosen by a 2-bit size code. A full-width bit chooses whether each operand is used at 128 bits or at only its low 64 bits.

An execution pipeline presents both operands, the size code and the width bit together with a valid strobe. One clock later the block returns the packed result with its own valid. A size/width combination that has no meaning is reported through a reserved flag, and the result for it is zero. The arithmetic is integer only, and each sum wraps within its lane.

Top module: `pairwise_lane_adder`

## Requirements
- R1: The size code sets the element width as 8 << size: code 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64.
- R2: With q_full=1 the working vector is the 256-bit value {op_b, op_a}. Result lane e, which is bits e*W +: W, is joined lane 2e plus joined lane 2e+1, for e from 0 to 128/W-1.
- R3: With q_full=0 the working vector is the 128-bit value {op_b[63:0], op_a[63:0]}. The 64/W result lanes are formed as in R2, and bits 127:64 of the result are zero.
- R4: Every lane sum wraps modulo 2^W, and no carry passes into the next lane.
- R5: The combination size=3 with q_full=0 is reserved. It sets out_reserved for exactly the one cycle that carries its out_valid, and the result for it is all zero.
- R6: out_valid is high exactly in the cycle after each cycle in which in_valid is high. out_result then holds the sum for the inputs presented with that strobe.
- R7: In a cycle that follows one with in_valid low, out_valid and out_reserved are low and out_result keeps its previous value.
- R8: While reset is asserted, out_valid, out_reserved and out_result are all zero.
- R9: With q_full=0, bits 127:64 of both operands have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 128 | First operand, placed in the lower half of the joined vector |
| op_b | input | 128 | Second operand, placed in the upper half of the joined vector |
| size | input | 2 | Element width code, width = 8 << size |
| q_full | input | 1 | 1 = 128-bit operands, 0 = 64-bit operands |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 128 | Packed pairwise sums |
| out_reserved | output | 1 | The accepted encoding was reserved |

## Verification
Every size code is tried with both settings of the width bit. Each of these combinations gets zeros, all ones, lanes that hold their top positive or most negative value, and pseudo-random words. The all-ones and sign-boundary patterns separate wrapping sums from sums that saturate or leak a carry into the next lane. Incrementing bytes, and the use of two different operands, show whether the lanes are paired in the right order and whether operand B truly lands in the upper half. Garbage in the upper operand halves with the width bit clear shows whether those bits are ignored. Gaps between strobes test that the output holds its value and that valid lasts for only one cycle.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int VEC_W     = 128;
  localparam int ELEM_MIN  = 8;
  localparam int NUM_SIZES = 4;
  localparam int SIZE_W    = $clog2(NUM_SIZES);
  localparam int HALF_W    = VEC_W / 2;
  localparam int JOIN_W    = 2 * VEC_W;
endpackage

// File: rtl/pla_rst_sync.sv
module pla_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pla_join.sv
module pla_join #(
  parameter int VEC_W = pla_pkg::VEC_W
) (
  input  logic [VEC_W-1:0]   src_lo,
  input  logic [VEC_W-1:0]   src_hi,
  input  logic               full,
  output logic [2*VEC_W-1:0] joined
);
  localparam int HALF = VEC_W / 2;

  always_comb begin
    if (full) joined = {src_hi, src_lo};
    else      joined = {{VEC_W{1'b0}}, src_hi[HALF-1:0], src_lo[HALF-1:0]};
  end
endmodule

// File: rtl/pla_lane_sum.sv
module pla_lane_sum #(
  parameter int VEC_W = pla_pkg::VEC_W,
  parameter int EW    = 8
) (
  input  logic [2*VEC_W-1:0] joined,
  output logic [VEC_W-1:0]   sums
);
  localparam int LANES = VEC_W / EW;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    assign sums[e*EW +: EW] = joined[(2*e)*EW +: EW] + joined[(2*e+1)*EW +: EW];
  end
endmodule

// File: rtl/pla_size_sel.sv
module pla_size_sel #(
  parameter int VEC_W     = pla_pkg::VEC_W,
  parameter int NUM_SIZES = pla_pkg::NUM_SIZES,
  parameter int SIZE_W    = pla_pkg::SIZE_W
) (
  input  logic [NUM_SIZES-1:0][VEC_W-1:0] cand,
  input  logic [SIZE_W-1:0]               size,
  input  logic                            full,
  output logic [VEC_W-1:0]                picked,
  output logic                            reserved
);
  localparam logic [SIZE_W-1:0] WIDEST = SIZE_W'(NUM_SIZES - 1);

  always_comb begin
    reserved = (size == WIDEST) && !full;
    picked   = reserved ? '0 : cand[size];
  end
endmodule

// File: rtl/pairwise_lane_adder.sv
module pairwise_lane_adder #(
  parameter int VEC_W     = pla_pkg::VEC_W,
  parameter int ELEM_MIN  = pla_pkg::ELEM_MIN,
  parameter int NUM_SIZES = pla_pkg::NUM_SIZES,
  parameter int SIZE_W    = pla_pkg::SIZE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  op_a,
  input  logic [VEC_W-1:0]  op_b,
  input  logic [SIZE_W-1:0] size,
  input  logic              q_full,
  output logic              out_valid,
  output logic [VEC_W-1:0]  out_result,
  output logic              out_reserved
);
  localparam int JOIN_W = 2 * VEC_W;

  logic                           rst_core_n;
  logic [JOIN_W-1:0]              joined;
  logic [NUM_SIZES-1:0][VEC_W-1:0] cand;
  logic [VEC_W-1:0]               picked;
  logic                           rsv_now;

  logic [VEC_W-1:0] res_d, res_q;
  logic             vld_d, vld_q;
  logic             rsv_d, rsv_q;

  pla_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_core_n)
  );

  pla_join #(.VEC_W(VEC_W)) u_join (
    .src_lo(op_a),
    .src_hi(op_b),
    .full  (q_full),
    .joined(joined)
  );

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    pla_lane_sum #(.VEC_W(VEC_W), .EW(ELEM_MIN << s)) u_sum (
      .joined(joined),
      .sums  (cand[s])
    );
  end

  pla_size_sel #(.VEC_W(VEC_W), .NUM_SIZES(NUM_SIZES), .SIZE_W(SIZE_W)) u_sel (
    .cand    (cand),
    .size    (size),
    .full    (q_full),
    .picked  (picked),
    .reserved(rsv_now)
  );

  // Next-state: result loads only on the strobe, flags are single-cycle.
  always_comb begin
    res_d = res_q;
    vld_d = in_valid;
    rsv_d = 1'b0;
    if (in_valid) begin
      res_d = picked;
      rsv_d = rsv_now;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
      rsv_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
      rsv_q <= rsv_d;
    end
  end

  assign out_valid    = vld_q;
  assign out_result   = res_q;
  assign out_reserved = rsv_q;
endmodule

// File: rtl/pla_checker.sv
module pla_checker #(
  parameter int VEC_W  = pla_pkg::VEC_W,
  parameter int SIZE_W = pla_pkg::SIZE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [SIZE_W-1:0] size,
  input logic              q_full,
  input logic              out_valid,
  input logic [VEC_W-1:0]  out_result,
  input logic              out_reserved
);
  localparam int HALF = VEC_W / 2;
  localparam logic [SIZE_W-1:0] WIDEST = '1;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_reserved)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result)); // R7

  AST_RSV_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == WIDEST && !q_full) |=> out_reserved); // R5

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_reserved |-> (out_result == '0 && out_valid)); // R5

  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !q_full) |=> (out_result[VEC_W-1:HALF] == '0)); // R3
endmodule

bind pairwise_lane_adder pla_checker #(.VEC_W(VEC_W), .SIZE_W(SIZE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .in_valid    (in_valid),
  .size        (size),
  .q_full      (q_full),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_reserved(out_reserved)
);

// File: tb/pairwise_lane_adder_bench.sv
`timescale 1ns/1ps
module pairwise_lane_adder_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] op_a = '0;
  logic [127:0] op_b = '0;
  logic [1:0]   size = '0;
  logic         q_full = 1'b0;
  logic         out_valid;
  logic [127:0] out_result;
  logic         out_reserved;

  int checks = 0;
  int errors = 0;
  logic [127:0] pats [8];

  always #10 clk = ~clk;

  pairwise_lane_adder u_pairwise_lane_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .size(size), .q_full(q_full), .out_valid(out_valid),
    .out_result(out_result), .out_reserved(out_reserved)
  );

  function automatic logic [127:0] model(logic [127:0] a, logic [127:0] b,
                                         int sz, bit q);
    logic [255:0] j, mask, lo, hi;
    logic [127:0] r;
    int w;
    w = 8 << sz;
    r = '0;
    if (!q && sz == 3) return r;
    j = q ? {b, a} : {128'b0, b[63:0], a[63:0]};
    mask = (256'd1 << w) - 256'd1;
    for (int e = 0; e < 128 / w; e++) begin
      lo = (j >> (2 * e * w)) & mask;
      hi = (j >> ((2 * e + 1) * w)) & mask;
      r = r | 128'(((lo + hi) & mask) << (e * w));
    end
    return r;
  endfunction

  task automatic chk(logic [127:0] act, logic [127:0] exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one strobe, then sample the registered outputs one cycle later.
  task automatic apply(logic [127:0] a, logic [127:0] b, int sz, bit q, string req);
    logic [127:0] exp;
    @(negedge clk);
    op_a = a; op_b = b; size = 2'(sz); q_full = q; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp = model(a, b, sz, q);
    chk(out_result, exp, req);
    chk({127'b0, out_valid}, 128'd1, "R6 valid");
    chk({127'b0, out_reserved}, {127'b0, (!q && sz == 3)}, "R5 flag");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] x;
    logic [127:0] held;
    x = 64'h9E3779B97F4A7C15;
    pats[0] = '0;
    pats[1] = '1;
    pats[2] = {16{8'h7F}};
    pats[3] = {16{8'h80}};
    for (int k = 0; k < 16; k++) pats[4][k*8 +: 8] = 8'(k + 1);
    for (int p = 5; p < 8; p++) begin
      x = x ^ (x << 13); x = x ^ (x >> 7); pats[p][63:0] = x;
      x = x ^ (x << 17); x = x ^ (x >> 9); pats[p][127:64] = x;
    end

    repeat (3) @(negedge clk);
    chk({125'b0, out_valid, out_reserved, |out_result}, 128'd0, "R8 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({126'b0, out_valid, out_reserved}, 128'd0, "R8 after release");

    // R1 R2 R3 sweep over all size/width combinations.
    for (int q = 0; q < 2; q++)
      for (int sz = 0; sz < 4; sz++)
        for (int pa = 0; pa < 8; pa++) begin
          apply(pats[pa], pats[pa], sz, q[0], q ? "R1 R2 same" : "R1 R3 same");
          apply(pats[pa], pats[(pa + 3) % 8], sz, q[0], q ? "R2 mixed" : "R3 mixed");
        end

    // R4 wrap: 0xFF+0xFF per byte lane gives 0xFE.
    apply('1, '1, 0, 1'b1, "R4 byte wrap");
    chk(out_result, {16{8'hFE}}, "R4 explicit");
    apply({2{64'h8000000000000000}}, '0, 3, 1'b1, "R4 64-bit wrap");
    chk(out_result, 128'd0, "R4 64-bit explicit");

    // R5 reserved with nonzero data.
    apply(pats[6], pats[7], 3, 1'b0, "R5 reserved");
    chk(out_result, 128'd0, "R5 zero result");

    // R9 upper halves ignored when q_full=0.
    apply({64'hDEADBEEFCAFEF00D, pats[4][63:0]}, {64'h0123456789ABCDEF, pats[5][63:0]},
          1, 1'b0, "R9 garbage");
    chk(out_result, model({64'b0, pats[4][63:0]}, {64'b0, pats[5][63:0]}, 1, 1'b0),
        "R9 compare");

    // R7 hold and quiet flags with no strobe.
    apply(pats[5], pats[6], 2, 1'b1, "R7 setup");
    held = out_result;
    apply(pats[6], pats[7], 3, 1'b0, "R7 reserved setup");
    held = out_result;
    op_a = pats[1]; op_b = pats[2]; size = 2'd0; q_full = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(out_result, held, "R7 hold");
      chk({126'b0, out_valid, out_reserved}, 128'd0, "R7 quiet");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule